// File: doc/BRIEF.md
# Dual-Mode Parallel Host Port

This block is the parallel microprocessor port of a display controller. A static mode input selects between a 6800-style bus, with a read/write direction line and an active-high enable strobe, and an 8080-style bus, with separate active-low write and read strobes. Both styles share an 8-bit data bus, an active-low chip select and a data/command select line. All host pins are registered once on the controller clock, and every transfer is judged from that sampled copy.

A write is taken when its strobe ends. With the select line high, the byte goes to display RAM at the current column, and the column then moves on by one. With the select line low, the byte goes to the command decoder as a one-cycle pulse. A read with the select line low returns the status byte. A read with it high returns the byte held in a one-stage pipeline register, and fetches the next column into that register when the strobe ends. For this reason the first read after the column is reloaded is a dummy read. The column is reloaded by the command decoder through a load input.

The tristate pad, the command decode and the RAM array sit outside the block. The RAM is expected to return read data one clock after a read request.

Top module: `host_bus_port`

## Requirements
- R1: With `mode_8080`=0, `cs_n` low, `rw_wrn` low and `en_rdn` high, the byte on `db_in` is delivered when `en_rdn` falls: a one-cycle `ram_we` at the current column when `dc`=1, or a one-cycle `cmd_valid` carrying the byte when `dc`=0.
- R2: With `mode_8080`=1 and `cs_n` low, a low pulse on `rw_wrn` is a write cycle, delivered when `rw_wrn` rises again and routed by `dc` exactly as in R1.
- R3: A read with `dc`=0 (6800: `rw_wrn`=1 and `en_rdn`=1; 8080: `en_rdn`=0 and `rw_wrn`=1) drives `status_in` on `db_out`, issues no `ram_re` and leaves the column unchanged.
- R4: A read with `dc`=1 returns the pipeline register, then fetches the current column into it and advances the column. After the column is loaded, the first read returns stale data and each later read returns the next consecutive byte.
- R5: Each RAM write and each data read advances the column by one, wrapping from COLS-1 to 0.
- R6: `col_load` sets the column to `col_load_val`, and takes priority over an increment in the same cycle. An access issued in that cycle uses the old column.
- R7: `db_oe` is high only during a read cycle with `cs_n` low. Strobe activity while `cs_n` is high produces no write, no command and no read.
- R8: After reset, `db_oe`, `cmd_valid`, `ram_we` and `ram_re` are low, `db_out` is 0, the column is 0 and the pipeline register holds 0.
- R9: A data read whose strobe starts in the cycle in which the previous fetch returns receives that freshly fetched byte.
- R10: Each strobe yields at most one one-cycle transfer, and no more than one of `cmd_valid`, `ram_we` and `ram_re` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low reset |
| mode_8080 | input | 1 | 0: 6800 bus style, 1: 8080 bus style (static) |
| cs_n | input | 1 | Chip select, active low |
| dc | input | 1 | 1: display data, 0: command/status |
| rw_wrn | input | 1 | 6800: 1 read / 0 write; 8080: write strobe, active low |
| en_rdn | input | 1 | 6800: enable, active high; 8080: read strobe, active low |
| db_in | input | DW | Data from host pad |
| db_out | output | DW | Data to host pad |
| db_oe | output | 1 | Pad output enable |
| status_in | input | DW | Status byte to return on command reads |
| cmd_valid | output | 1 | One-cycle command byte pulse |
| cmd_byte | output | DW | Command byte |
| col_load | input | 1 | Column load from the command decoder |
| col_load_val | input | CW | Column value to load |
| ram_we | output | 1 | RAM write request |
| ram_re | output | 1 | RAM read request; data expected one cycle later |
| ram_addr | output | CW | Current column address |
| ram_wdata | output | DW | RAM write data |
| ram_rdata | input | DW | RAM read data |

## Verification
Two functions can meet in one cycle. The first pair is the return of a pipeline fetch and the start of the next read strobe. The bench provokes it by dropping a data read strobe for a single clock and raising it again at once. It then requires the second read to deliver the byte just fetched, not the older register contents. The second pair is a column load from the decoder landing in the same cycle as the end of a RAM write. That write must reach the old column, and the following write must land at the loaded column.

// File: rtl/host_bus_port.sv
module host_bus_port #(
  parameter int DW   = 8,
  parameter int COLS = 128,
  localparam int CW  = (COLS > 1) ? $clog2(COLS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_8080,
  input  logic          cs_n,
  input  logic          dc,
  input  logic          rw_wrn,
  input  logic          en_rdn,
  input  logic [DW-1:0] db_in,
  output logic [DW-1:0] db_out,
  output logic          db_oe,
  input  logic [DW-1:0] status_in,
  output logic          cmd_valid,
  output logic [DW-1:0] cmd_byte,
  input  logic          col_load,
  input  logic [CW-1:0] col_load_val,
  output logic          ram_we,
  output logic          ram_re,
  output logic [CW-1:0] ram_addr,
  output logic [DW-1:0] ram_wdata,
  input  logic [DW-1:0] ram_rdata
);

  logic          s_cs_n, s_dc, s_rw, s_en;
  logic [DW-1:0] s_db;
  logic          wr_q, rd_q, wr_dc, rd_dc, fill_q;
  logic [DW-1:0] wr_byte, pipe;
  logic [CW-1:0] col;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_cs_n <= 1'b1;
      s_dc   <= 1'b0;
      s_rw   <= 1'b0;
      s_en   <= 1'b0;
      s_db   <= '0;
    end else begin
      s_cs_n <= cs_n;
      s_dc   <= dc;
      s_rw   <= rw_wrn;
      s_en   <= en_rdn;
      s_db   <= db_in;
    end
  end

  wire wr_act   = !s_cs_n && (mode_8080 ? !s_rw : (s_en && !s_rw));
  wire rd_act   = !s_cs_n && (mode_8080 ? (!s_en && s_rw) : (s_en && s_rw));
  wire wr_trail = wr_q && !wr_act;
  wire rd_lead  = rd_act && !rd_q;
  wire rd_trail = rd_q && !rd_act;

  wire [CW-1:0] col_nxt = (col == CW'(COLS - 1)) ? '0 : col + 1'b1;

  assign cmd_valid = wr_trail && !wr_dc;
  assign cmd_byte  = wr_byte;
  assign ram_we    = wr_trail && wr_dc;
  assign ram_wdata = wr_byte;
  assign ram_re    = rd_trail && rd_dc;
  assign ram_addr  = col;
  assign db_oe     = rd_act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q    <= 1'b0;
      rd_q    <= 1'b0;
      wr_dc   <= 1'b0;
      rd_dc   <= 1'b0;
      wr_byte <= '0;
    end else begin
      wr_q <= wr_act;
      rd_q <= rd_act;
      if (wr_act) begin
        wr_byte <= s_db;
        wr_dc   <= s_dc;
      end
      if (rd_lead) rd_dc <= s_dc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) col <= '0;
    else if (col_load) col <= col_load_val;
    else if (ram_we || ram_re) col <= col_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill_q <= 1'b0;
      pipe   <= '0;
      db_out <= '0;
    end else begin
      fill_q <= ram_re;
      if (fill_q) pipe <= ram_rdata;
      if (rd_lead) db_out <= s_dc ? (fill_q ? ram_rdata : pipe) : status_in;
    end
  end

endmodule

module host_bus_port_chk #(
  parameter int DW   = 8,
  parameter int COLS = 128,
  localparam int CW  = (COLS > 1) ? $clog2(COLS) : 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cs_n,
  input logic          db_oe,
  input logic          cmd_valid,
  input logic          col_load,
  input logic [CW-1:0] col_load_val,
  input logic          ram_we,
  input logic          ram_re,
  input logic [CW-1:0] ram_addr
);

  assert_oe_needs_cs_R7: assert property (@(posedge clk) disable iff (!rst_n)
    db_oe |-> $past(!cs_n));

  assert_one_transfer_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({cmd_valid, ram_we, ram_re}) <= 1);

  assert_cmd_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !cmd_valid);

  assert_no_write_while_driving_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> !db_oe);

  assert_col_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((ram_we || ram_re) && !col_load) |=>
      ram_addr == (($past(ram_addr) == CW'(COLS - 1)) ? '0 : $past(ram_addr) + 1'b1));

  assert_col_load_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    col_load |=> ram_addr == $past(col_load_val));

  assert_col_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!col_load && !ram_we && !ram_re) |=> $stable(ram_addr));

endmodule

bind host_bus_port host_bus_port_chk #(.DW(DW), .COLS(COLS)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .db_oe(db_oe), .cmd_valid(cmd_valid),
  .col_load(col_load), .col_load_val(col_load_val), .ram_we(ram_we),
  .ram_re(ram_re), .ram_addr(ram_addr)
);

// File: tb/test_host_bus_port.sv
module test_host_bus_port;
  localparam int DW = 8;
  localparam int COLS = 128;
  localparam int CW = $clog2(COLS);

  logic clk = 0, rst_n = 0, mode_8080 = 0, cs_n = 1, dc = 0, rw_wrn = 1, en_rdn = 0;
  logic [DW-1:0] db_in = '0, status_in = 8'hA5;
  logic [DW-1:0] db_out, cmd_byte, ram_wdata, ram_rdata;
  logic db_oe, cmd_valid, ram_we, ram_re, col_load = 0;
  logic [CW-1:0] col_load_val = '0, ram_addr;

  always #5 clk = ~clk;

  host_bus_port #(.DW(DW), .COLS(COLS)) i_host_bus_port (
    .clk(clk), .rst_n(rst_n), .mode_8080(mode_8080), .cs_n(cs_n), .dc(dc),
    .rw_wrn(rw_wrn), .en_rdn(en_rdn), .db_in(db_in), .db_out(db_out), .db_oe(db_oe),
    .status_in(status_in), .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
    .col_load(col_load), .col_load_val(col_load_val), .ram_we(ram_we), .ram_re(ram_re),
    .ram_addr(ram_addr), .ram_wdata(ram_wdata), .ram_rdata(ram_rdata));

  logic [DW-1:0] ram [COLS];
  logic [DW-1:0] ref_mem [COLS];
  logic [DW-1:0] rdq = '0;
  initial for (int i = 0; i < COLS; i++) begin ram[i] = '0; ref_mem[i] = '0; end
  always @(posedge clk) begin
    if (ram_we) ram[ram_addr] <= ram_wdata;
    if (ram_re) rdq <= ram[ram_addr];
  end
  assign ram_rdata = rdq;

  int n_cmd = 0, n_we = 0, n_re = 0, n_multi = 0, n_long = 0;
  logic [DW-1:0] last_cmd = '0;
  logic prev_cmd = 0;
  always @(posedge clk) if (rst_n) begin
    if (cmd_valid) begin n_cmd <= n_cmd + 1; last_cmd <= cmd_byte; end
    if (ram_we) n_we <= n_we + 1;
    if (ram_re) n_re <= n_re + 1;
    if ((32'(cmd_valid) + 32'(ram_we) + 32'(ram_re)) > 1) n_multi <= n_multi + 1;
    if (cmd_valid && prev_cmd) n_long <= n_long + 1;
    prev_cmd <= cmd_valid;
  end

  int tests = 0, fails = 0;
  int exp_col = 0;
  logic [DW-1:0] exp_pipe = '0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int nxt(input int c);
    return (c == COLS - 1) ? 0 : c + 1;
  endfunction

  task automatic set_mode(input logic m);
    @(negedge clk);
    mode_8080 = m; cs_n = 1;
    rw_wrn = 1; en_rdn = m ? 1'b1 : 1'b0;
  endtask

  task automatic strobe_on(input logic rd);
    if (mode_8080) begin if (rd) en_rdn = 0; else rw_wrn = 0; end
    else begin rw_wrn = rd; en_rdn = 1; end
  endtask

  task automatic strobe_off();
    if (mode_8080) begin rw_wrn = 1; en_rdn = 1; end
    else en_rdn = 0;
  endtask

  task automatic bus_write(input logic d, input logic [DW-1:0] v, input bit load_at_end,
                           input int load_to);
    @(negedge clk); dc = d; db_in = v; cs_n = 0; strobe_on(0);
    repeat (3) @(negedge clk);
    strobe_off();
    @(negedge clk); cs_n = 1;
    if (load_at_end) begin
      chk(ram_we === 1'b1, "R6 write ends in load cycle", ram_we, 1);
      col_load = 1; col_load_val = CW'(load_to);
      @(negedge clk); col_load = 0;
    end
    repeat (3) @(negedge clk);
    if (d) begin
      ref_mem[exp_col] = v;
      exp_col = load_at_end ? load_to : nxt(exp_col);
    end
  endtask

  task automatic bus_read(input logic d, output logic [DW-1:0] v);
    @(negedge clk); dc = d; cs_n = 0; strobe_on(1);
    repeat (3) @(negedge clk);
    chk(db_oe === 1'b1, "R7 oe during read", db_oe, 1);
    v = db_out;
    strobe_off();
    @(negedge clk); cs_n = 1;
    repeat (3) @(negedge clk);
    chk(db_oe === 1'b0, "R7 oe released", db_oe, 0);
  endtask

  task automatic set_col(input int c);
    @(negedge clk); col_load = 1; col_load_val = CW'(c);
    @(negedge clk); col_load = 0;
    exp_col = c;
  endtask

  task automatic data_read_check(input string req);
    logic [DW-1:0] v;
    bus_read(1, v);
    chk(v === exp_pipe, req, v, exp_pipe);
    exp_pipe = ref_mem[exp_col];
    exp_col = nxt(exp_col);
  endtask

  task automatic t_reset();
    chk(db_oe === 0 && cmd_valid === 0 && ram_we === 0 && ram_re === 0,
        "R8 control outputs low", {db_oe, cmd_valid, ram_we, ram_re}, 0);
    chk(db_out === 0, "R8 db_out", db_out, 0);
    chk(ram_addr === 0, "R8 column", ram_addr, 0);
  endtask

  task automatic t_write_route(input logic m, input string req);
    int c0, w0, col_before;
    set_mode(m);
    c0 = n_cmd; w0 = n_we; col_before = exp_col;
    bus_write(0, 8'h3C ^ {7'd0, m}, 0, 0);
    chk(n_cmd == c0 + 1 && last_cmd === (8'h3C ^ {7'd0, m}), {req, " command"}, last_cmd, 8'h3C ^ {7'd0, m});
    chk(n_we == w0, {req, " command not to RAM"}, n_we, w0);
    bus_write(1, 8'h5A + {7'd0, m}, 0, 0);
    chk(ram[col_before] === 8'h5A + {7'd0, m}, {req, " data to RAM"}, ram[col_before], 8'h5A + {7'd0, m});
    chk(n_cmd == c0 + 1 && n_we == w0 + 1, {req, " one RAM write"}, n_we, w0 + 1);
  endtask

  task automatic t_status(input logic m);
    logic [DW-1:0] v;
    int r0, col_before;
    set_mode(m);
    r0 = n_re; col_before = exp_col;
    status_in = m ? 8'hC3 : 8'h96;
    bus_read(0, v);
    chk(v === status_in, "R3 status returned", v, status_in);
    chk(n_re == r0, "R3 no RAM read", n_re, r0);
    bus_write(1, 8'h77, 0, 0);
    chk(ram[col_before] === 8'h77, "R3 column unchanged", ram[col_before], 8'h77);
  endtask

  task automatic t_dummy(input logic m);
    set_mode(m);
    set_col(5);
    bus_write(1, 8'h11, 0, 0);
    bus_write(1, 8'h22, 0, 0);
    bus_write(1, 8'h33, 0, 0);
    set_col(5);
    data_read_check("R4 dummy read is stale");
    data_read_check("R4 first valid byte");
    data_read_check("R4 next byte");
    data_read_check("R4 third byte");
  endtask

  task automatic t_wrap();
    set_mode(0);
    set_col(COLS - 1);
    bus_write(1, 8'hE1, 0, 0);
    bus_write(1, 8'hE2, 0, 0);
    chk(ram[COLS-1] === 8'hE1, "R5 last column", ram[COLS-1], 8'hE1);
    chk(ram[0] === 8'hE2, "R5 wrap to 0", ram[0], 8'hE2);
  endtask

  task automatic t_load_priority();
    int old;
    set_mode(1);
    set_col(40);
    old = exp_col;
    bus_write(1, 8'h9D, 1, 60);
    chk(ram[old] === 8'h9D, "R6 access uses old column", ram[old], 8'h9D);
    bus_write(1, 8'h4B, 0, 0);
    chk(ram[60] === 8'h4B, "R6 load wins over increment", ram[60], 8'h4B);
    chk(ram[old + 1] !== 8'h4B, "R6 no increment applied", ram[old + 1], 0);
  endtask

  task automatic t_cs_gate(input logic m);
    int c0, w0, r0, oe_seen;
    set_mode(m);
    c0 = n_cmd; w0 = n_we; r0 = n_re; oe_seen = 0;
    for (int k = 0; k < 2; k++) begin
      @(negedge clk); dc = k[0]; db_in = 8'hF0;
      strobe_on(0);
      repeat (3) begin @(negedge clk); if (db_oe) oe_seen++; end
      strobe_off();
      @(negedge clk); strobe_on(1);
      repeat (3) begin @(negedge clk); if (db_oe) oe_seen++; end
      strobe_off();
      repeat (3) begin @(negedge clk); if (db_oe) oe_seen++; end
    end
    chk(oe_seen == 0, "R7 no oe with cs high", oe_seen, 0);
    chk(n_cmd == c0 && n_we == w0 && n_re == r0, "R7 no transfer with cs high",
        n_cmd + n_we + n_re, c0 + w0 + r0);
  endtask

  task automatic t_back_to_back(input logic m);
    logic [DW-1:0] v1, v2, e2;
    set_mode(m);
    set_col(20);
    bus_write(1, 8'hA1, 0, 0);
    bus_write(1, 8'hB2, 0, 0);
    set_col(20);
    data_read_check("R9 prime");
    @(negedge clk); dc = 1; cs_n = 0; strobe_on(1);
    repeat (3) @(negedge clk);
    v1 = db_out;
    strobe_off();
    @(negedge clk); strobe_on(1);
    repeat (3) @(negedge clk);
    v2 = db_out;
    strobe_off();
    @(negedge clk); cs_n = 1;
    repeat (3) @(negedge clk);
    chk(v1 === exp_pipe, "R9 first of pair", v1, exp_pipe);
    e2 = ref_mem[exp_col];
    chk(v2 === e2, "R9 fetch bypass", v2, e2);
    exp_col = nxt(nxt(exp_col));
    exp_pipe = ref_mem[nxt(exp_col) == 0 ? COLS - 1 : exp_col - 1];
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    repeat (2) @(negedge clk);
    t_write_route(0, "R1");
    t_write_route(1, "R2");
    t_status(0);
    t_status(1);
    t_dummy(0);
    t_dummy(1);
    t_wrap();
    t_load_priority();
    t_cs_gate(0);
    t_cs_gate(1);
    t_back_to_back(0);
    t_back_to_back(1);
    chk(n_multi == 0, "R10 single transfer per cycle", n_multi, 0);
    chk(n_long == 0, "R10 command is one cycle", n_long, 0);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule